// File: doc/BRIEF.md
# Cache Way Allocation Enforcer

This block decides which way of a 16-way set-associative last-level cache receives a new line when a miss needs room. Each service class owns a way mask. Each core carries an association register that names its current class. A request names its issuing core, and the block looks up that core's class and then the class's mask. The victim is then chosen only among the ways the mask permits. The cache arrays, coherence and the memory side belong to other blocks. This block only selects victims and holds the configuration behind that choice.

Software programs the masks and the core-to-class mappings through a one-cycle write port and reads them back through a combinational read port. A mask is accepted only if its set bits form one unbroken run. Any other mask, including zero, is refused and raises a sticky error flag. Masks of different classes may overlap so that classes share capacity, or they may be disjoint so that classes are isolated. Among the permitted ways an empty (invalid) way is filled first. When every permitted way is full, a round-robin pointer kept for each set picks the victim. A hit is reported back unchanged, whatever the requester's mask.

Top module: `way_alloc_enforcer`

## Requirements
- R1: After reset every class mask reads 0xFFFF, every core maps to class 0, `cfg_err` is 0, `resp_valid` is 0 and every set's round-robin pointer is at way 0.
- R2: A write with `cfg_we`=1 and `cfg_op`=0 of a mask that is nonzero and has one contiguous run of ones replaces the mask of class `cfg_idx`; it reads back on `rd_data` with `rd_map`=0 and `rd_idx` set to the class.
- R3: A mask write whose ones are not contiguous, or whose value is zero, leaves the stored mask unchanged and sets `cfg_err`; `cfg_err` stays 1 until a write with `cfg_op`=2.
- R4: A write with `cfg_op`=1 sets the class of core `cfg_idx` to `cfg_wdata[1:0]`; it reads back zero-extended on `rd_data` with `rd_map`=1.
- R5: A request uses the class that its core is mapped to in the cycle the request is accepted, so rewriting a core's mapping redirects that core's later requests.
- R6: Every cycle with `req_valid`=1 is answered by `resp_valid`=1 in the next cycle and by no other response; on a miss `resp_way` is one-hot.
- R7: If `req_hit` has any bit set, the response has `resp_hit`=1 and `resp_way` equal to `req_hit`, whatever the class mask, and the set's pointer does not move.
- R8: On a miss, if any permitted way has its `req_line_valid` bit at 0, the victim is the lowest-numbered such way, and the pointer does not move.
- R9: On a miss with every permitted way valid, the victim is the first permitted way at or above the set's pointer (wrapping from 15 to 0), and that set's pointer becomes the victim index plus one, modulo 16; other sets' pointers are untouched.
- R10: A miss victim always lies inside the requesting class's mask, both for masks that overlap another class's and for disjoint ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_op | input | 2 | 0 = class mask, 1 = core class, 2 = clear error |
| cfg_idx | input | 2 | Class or core index of the write |
| cfg_wdata | input | 16 | Mask value, or class number in bits 1:0 |
| rd_map | input | 1 | Read select: 0 = class mask, 1 = core class |
| rd_idx | input | 2 | Class or core index to read |
| rd_data | output | 16 | Read value (combinational) |
| cfg_err | output | 1 | Sticky flag for a refused mask write |
| req_valid | input | 1 | Request present this cycle |
| req_core | input | 2 | Issuing core |
| req_set | input | 4 | Set index of the request |
| req_line_valid | input | 16 | Valid bit of each way in the set |
| req_hit | input | 16 | Tag-match vector of the set |
| resp_valid | output | 1 | Response pulse, one cycle after a request |
| resp_hit | output | 1 | Response is a hit |
| resp_way | output | 16 | Hit vector or one-hot victim way |

## Verification
The assertions assume that `req_hit` has at most one bit set and that a request's hit vector and valid bits describe one consistent set. They also assume that the core and set indices stay within the configured counts. The bench never drives a multi-bit hit vector and keeps all indices within range. It also never changes the configuration in the same cycle as a request, so each response can be predicted from the configuration that was in place when the request was sent. The in-mask and fill-first properties compare each response with the mask and valid bits sampled one cycle earlier, so a mid-stream mask rewrite is not an assumption they rely on.

// File: rtl/wae_pkg.sv
// Shared encodings for the way allocation enforcer.
// Assumes: the configuration port carries a two-bit operation code.
package wae_pkg;
    typedef enum logic [1:0] {
        CFG_MASK   = 2'd0,
        CFG_MAP    = 2'd1,
        CFG_CLRERR = 2'd2
    } cfg_op_e;
endpackage

// File: rtl/wae_cfg_regs.sv
// Class mask table, core-to-class table and sticky error flag.
// Validates mask writes (nonzero, one contiguous run of ones) and serves
// a software read port plus the lookup used by each request.
// Assumes: class and core counts are powers of two that match the index widths.
module wae_cfg_regs
    import wae_pkg::*;
#(
    parameter int WAYS    = 16,
    parameter int CLASSES = 4,
    parameter int CORES   = 4,
    parameter int CLS_W   = 2,
    parameter int CORE_W  = 2,
    parameter int IDX_W   = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [1:0]        cfg_op,
    input  logic [IDX_W-1:0]  cfg_idx,
    input  logic [WAYS-1:0]   cfg_wdata,
    input  logic              rd_map,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [WAYS-1:0]   rd_data,
    input  logic [CORE_W-1:0] lk_core,
    output logic [WAYS-1:0]   lk_mask,
    output logic              cfg_err
);
    logic [WAYS-1:0]  mask_q [CLASSES];
    logic [CLS_W-1:0] map_q  [CORES];

    // Legal mask: nonzero, and adding its lowest set bit clears every set bit.
    function automatic logic mask_ok(input logic [WAYS-1:0] m);
        logic [WAYS-1:0] low;
        low = m & (~m + WAYS'(1));
        return (m != '0) && ((m & (m + low)) == '0);
    endfunction

    // Configuration writes, with refusal of illegal masks.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int c = 0; c < CLASSES; c++) mask_q[c] <= '1;
            for (int k = 0; k < CORES; k++)   map_q[k]  <= '0;
            cfg_err <= 1'b0;
        end else if (cfg_we) begin
            case (cfg_op)
                CFG_MASK: begin
                    if (mask_ok(cfg_wdata)) mask_q[cfg_idx] <= cfg_wdata;
                    else                    cfg_err         <= 1'b1;
                end
                CFG_MAP:    map_q[cfg_idx] <= cfg_wdata[CLS_W-1:0];
                CFG_CLRERR: cfg_err <= 1'b0;
                default: ;
            endcase
        end
    end

    // Software read port.
    always_comb begin
        if (rd_map) rd_data = WAYS'(map_q[rd_idx]);
        else        rd_data = mask_q[rd_idx];
    end

    // Request lookup: core -> class -> mask.
    assign lk_mask = mask_q[map_q[lk_core]];

    generate
        for (genvar g = 0; g < CLASSES; g++) begin : g_mask_chk
            assert_mask_legal_R2: assert property (@(posedge clk) disable iff (!rst_n)
                mask_ok(mask_q[g]));
        end
    endgenerate

    assert_err_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_err && !(cfg_we && cfg_op == CFG_CLRERR) |=> cfg_err);

endmodule

// File: rtl/wae_victim_pick.sv
// Combinational victim choice inside an allowed-way mask.
// An invalid allowed way wins (lowest index first); otherwise a rotating
// search starts at the set's pointer and returns the pointer's next value.
// Assumes: allow is nonzero, WAYS is a power of two.
module wae_victim_pick #(
    parameter int WAYS  = 16,
    parameter int PTR_W = 4
) (
    input  logic [WAYS-1:0]  allow,
    input  logic [WAYS-1:0]  line_valid,
    input  logic [PTR_W-1:0] ptr,
    output logic [WAYS-1:0]  way,
    output logic             use_rr,
    output logic [PTR_W-1:0] nxt_ptr
);
    logic [WAYS-1:0] inv;

    // Pick either the lowest empty allowed way or the next allowed way in rotation.
    always_comb begin
        logic found;
        int   j;
        inv     = allow & ~line_valid;
        way     = '0;
        use_rr  = 1'b0;
        nxt_ptr = ptr;
        found   = 1'b0;
        j       = 0;
        if (inv != '0) begin
            for (int i = WAYS - 1; i >= 0; i--) begin
                if (inv[i]) way = WAYS'(1) << i;
            end
        end else begin
            use_rr = 1'b1;
            for (int i = 0; i < WAYS; i++) begin
                j = (int'(ptr) + i) % WAYS;
                if (!found && allow[j]) begin
                    found   = 1'b1;
                    way     = WAYS'(1) << j;
                    nxt_ptr = PTR_W'((j + 1) % WAYS);
                end
            end
        end
    end
endmodule

// File: rtl/way_alloc_enforcer.sv
// Top of the way allocation enforcer: configuration tables, victim choice
// confined to the requester's class mask, per-set round-robin pointers and a
// registered response one cycle after each request.
// Assumes: req_hit is zero or one-hot; indices are within the configured counts.
module way_alloc_enforcer #(
    parameter  int NUM_WAYS    = 16,
    parameter  int NUM_CLASSES = 4,
    parameter  int NUM_CORES   = 4,
    parameter  int NUM_SETS    = 16,
    localparam int CLS_W  = $clog2(NUM_CLASSES),
    localparam int CORE_W = $clog2(NUM_CORES),
    localparam int SET_W  = $clog2(NUM_SETS),
    localparam int PTR_W  = $clog2(NUM_WAYS),
    localparam int IDX_W  = (CLS_W > CORE_W) ? CLS_W : CORE_W
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cfg_we,
    input  logic [1:0]          cfg_op,
    input  logic [IDX_W-1:0]    cfg_idx,
    input  logic [NUM_WAYS-1:0] cfg_wdata,
    input  logic                rd_map,
    input  logic [IDX_W-1:0]    rd_idx,
    output logic [NUM_WAYS-1:0] rd_data,
    output logic                cfg_err,
    input  logic                req_valid,
    input  logic [CORE_W-1:0]   req_core,
    input  logic [SET_W-1:0]    req_set,
    input  logic [NUM_WAYS-1:0] req_line_valid,
    input  logic [NUM_WAYS-1:0] req_hit,
    output logic                resp_valid,
    output logic                resp_hit,
    output logic [NUM_WAYS-1:0] resp_way
);
    logic [NUM_WAYS-1:0] lk_mask;
    logic [NUM_WAYS-1:0] pick_way;
    logic                pick_rr;
    logic [PTR_W-1:0]    pick_nxt;
    logic [PTR_W-1:0]    ptr_q [NUM_SETS];

    wae_cfg_regs #(
        .WAYS(NUM_WAYS), .CLASSES(NUM_CLASSES), .CORES(NUM_CORES),
        .CLS_W(CLS_W), .CORE_W(CORE_W), .IDX_W(IDX_W)
    ) u_cfg (
        .clk(clk), .rst_n(rst_n),
        .cfg_we(cfg_we), .cfg_op(cfg_op), .cfg_idx(cfg_idx), .cfg_wdata(cfg_wdata),
        .rd_map(rd_map), .rd_idx(rd_idx), .rd_data(rd_data),
        .lk_core(req_core), .lk_mask(lk_mask), .cfg_err(cfg_err)
    );

    wae_victim_pick #(.WAYS(NUM_WAYS), .PTR_W(PTR_W)) u_pick (
        .allow(lk_mask), .line_valid(req_line_valid), .ptr(ptr_q[req_set]),
        .way(pick_way), .use_rr(pick_rr), .nxt_ptr(pick_nxt)
    );

    // Register the response and advance the set pointer on round-robin fills.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            resp_valid <= 1'b0;
            resp_hit   <= 1'b0;
            resp_way   <= '0;
            for (int s = 0; s < NUM_SETS; s++) ptr_q[s] <= '0;
        end else begin
            resp_valid <= req_valid;
            if (req_valid) begin
                if (req_hit != '0) begin
                    resp_hit <= 1'b1;
                    resp_way <= req_hit;
                end else begin
                    resp_hit <= 1'b0;
                    resp_way <= pick_way;
                    if (pick_rr) ptr_q[req_set] <= pick_nxt;
                end
            end
        end
    end

    assert_resp_next_cycle_R6: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> resp_valid);
    assert_no_stray_resp_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !resp_valid);
    assert_victim_onehot_R6: assert property (@(posedge clk) disable iff (!rst_n)
        resp_valid && !resp_hit |-> $countones(resp_way) == 1);
    assert_victim_in_mask_R10: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_hit == '0 |=> (resp_way & ~$past(lk_mask)) == '0);
    assert_hit_reported_R7: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_hit != '0 |=> resp_hit && resp_way == $past(req_hit));
    assert_fill_invalid_R8: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_hit == '0 && (lk_mask & ~req_line_valid) != '0
        |=> (resp_way & $past(req_line_valid)) == '0);

endmodule

// File: tb/way_alloc_enforcer_test.sv
// Scoreboard bench: the driver predicts each response and queues it,
// the monitor pops and compares on every response pulse.
module way_alloc_enforcer_test;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 20000;

    typedef struct packed {
        logic        hit;
        logic [15:0] way;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [1:0]  cfg_op = '0;
    logic [1:0]  cfg_idx = '0;
    logic [15:0] cfg_wdata = '0;
    logic        rd_map = 1'b0;
    logic [1:0]  rd_idx = '0;
    logic [15:0] rd_data;
    logic        cfg_err;
    logic        req_valid = 1'b0;
    logic [1:0]  req_core = '0;
    logic [3:0]  req_set = '0;
    logic [15:0] req_line_valid = '0;
    logic [15:0] req_hit = '0;
    logic        resp_valid;
    logic        resp_hit;
    logic [15:0] resp_way;

    int    n_chk = 0;
    int    n_fail = 0;
    exp_t  exp_q[$];
    string tag_q[$];
    int    m_mask [4];
    int    m_map  [4];
    int    m_ptr  [16];

    way_alloc_enforcer uut (
        .clk(clk), .rst_n(rst_n),
        .cfg_we(cfg_we), .cfg_op(cfg_op), .cfg_idx(cfg_idx), .cfg_wdata(cfg_wdata),
        .rd_map(rd_map), .rd_idx(rd_idx), .rd_data(rd_data), .cfg_err(cfg_err),
        .req_valid(req_valid), .req_core(req_core), .req_set(req_set),
        .req_line_valid(req_line_valid), .req_hit(req_hit),
        .resp_valid(resp_valid), .resp_hit(resp_hit), .resp_way(resp_way)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    task automatic chk(string r, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", r, act, exp);
        end
    endtask

    // Contiguity by counting runs of ones, as the requirement states it.
    function automatic bit legal(logic [15:0] m);
        int runs = 0;
        for (int i = 0; i < 16; i++)
            if (m[i] && (i == 0 || !m[i-1])) runs++;
        return runs == 1;
    endfunction

    task automatic cfg_write(logic [1:0] op, int idx, logic [15:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_op = op; cfg_idx = 2'(idx); cfg_wdata = d;
        if (op == 2'd0 && legal(d)) m_mask[idx] = int'(d);
        if (op == 2'd1) m_map[idx] = int'(d[1:0]);
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic rd_chk(logic sel, int idx, logic [15:0] exp, string r);
        @(negedge clk);
        rd_map = sel; rd_idx = 2'(idx);
        #1;
        chk(r, 32'(rd_data), 32'(exp));
    endtask

    // Driver: predict the response from the requirements and queue it.
    task automatic send(int core, int set, logic [15:0] lv, logic [15:0] hit, string r);
        exp_t e;
        logic [15:0] allow;
        logic [15:0] inv;
        e.hit = 1'b0; e.way = '0;
        if (hit != '0) begin
            e.hit = 1'b1; e.way = hit;
        end else begin
            allow = 16'(m_mask[m_map[core]]);
            inv = allow & ~lv;
            if (inv != '0) begin
                for (int i = 15; i >= 0; i--) if (inv[i]) e.way = 16'(1) << i;
            end else begin
                for (int i = 0; i < 16; i++) begin
                    int j = (m_ptr[set] + i) % 16;
                    if (e.way == '0 && allow[j]) begin
                        e.way = 16'(1) << j;
                        m_ptr[set] = (j + 1) % 16;
                    end
                end
            end
        end
        @(negedge clk);
        req_valid = 1'b1; req_core = 2'(core); req_set = 4'(set);
        req_line_valid = lv; req_hit = hit;
        exp_q.push_back(e);
        tag_q.push_back(r);
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            req_valid = 1'b0; req_hit = '0;
        end
    endtask

    // Monitor: compare each response pulse with the oldest prediction.
    always @(negedge clk) begin
        if (rst_n && resp_valid) begin
            if (exp_q.size() == 0) begin
                chk("R6 stray response", 32'(resp_way), 32'hFFFF_FFFF);
            end else begin
                exp_t  e;
                string r;
                e = exp_q.pop_front();
                r = tag_q.pop_front();
                chk(r, {15'd0, resp_hit, resp_way}, {15'd0, e.hit, e.way});
            end
        end
    end

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL R6 watchdog actual=timeout expected=finish");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        for (int c = 0; c < 4; c++) begin m_mask[c] = 'hFFFF; m_map[c] = 0; end
        for (int s = 0; s < 16; s++) m_ptr[s] = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        for (int c = 0; c < 4; c++) rd_chk(1'b0, c, 16'hFFFF, "R1 mask reset");
        for (int k = 0; k < 4; k++) rd_chk(1'b1, k, 16'h0000, "R1 map reset");
        chk("R1 err reset", 32'(cfg_err), 0);
        chk("R1 resp_valid reset", 32'(resp_valid), 0);

        // R8 then R9 under the full mask
        send(0, 0, 16'h0000, 16'h0, "R8 empty set fills way0");
        send(0, 0, 16'hFFFF, 16'h0, "R9 rr from reset ptr");
        send(0, 0, 16'hFFFF, 16'h0, "R9 rr second");
        send(0, 0, 16'hFFFF, 16'h0, "R9 rr third");
        idle(3);

        // R2: legal masks, overlapping (1,3) and disjoint (1,2)
        cfg_write(2'd0, 1, 16'h00F0);
        cfg_write(2'd0, 2, 16'h0F00);
        cfg_write(2'd0, 3, 16'h00FC);
        rd_chk(1'b0, 1, 16'h00F0, "R2 mask1");
        rd_chk(1'b0, 2, 16'h0F00, "R2 mask2");
        rd_chk(1'b0, 3, 16'h00FC, "R2 mask3");
        chk("R2 no err on legal", 32'(cfg_err), 0);

        // R3: illegal masks refused, error sticky until cleared
        cfg_write(2'd0, 1, 16'h0F0F);
        rd_chk(1'b0, 1, 16'h00F0, "R3 noncontiguous refused");
        chk("R3 err set", 32'(cfg_err), 1);
        cfg_write(2'd0, 2, 16'h0000);
        rd_chk(1'b0, 2, 16'h0F00, "R3 zero refused");
        cfg_write(2'd0, 0, 16'hFFFF);
        chk("R3 err sticky", 32'(cfg_err), 1);
        cfg_write(2'd2, 0, 16'h0000);
        chk("R3 err cleared", 32'(cfg_err), 0);

        // R4: core mappings
        cfg_write(2'd1, 1, 16'h0001);
        cfg_write(2'd1, 2, 16'h0002);
        cfg_write(2'd1, 3, 16'h0003);
        rd_chk(1'b1, 1, 16'h0001, "R4 map core1");
        rd_chk(1'b1, 3, 16'h0003, "R4 map core3");

        // R9/R10: round robin inside class 1, with wrap
        for (int n = 0; n < 5; n++) send(1, 3, 16'hFFFF, 16'h0, "R9 R10 rr in mask1");
        // R8: invalid way inside mask, then invalid way only outside mask
        send(1, 5, 16'hFFDF, 16'h0, "R8 invalid inside mask");
        send(1, 5, 16'hFFFE, 16'h0, "R10 invalid outside mask ignored");
        // R10: overlapping class 3 shares set 3's rotation
        send(3, 3, 16'hFFFF, 16'h0, "R10 overlap mask3");
        // R7: hit outside mask, pointer untouched
        send(2, 3, 16'hFFFF, 16'h0001, "R7 hit outside mask");
        send(2, 3, 16'hFFFF, 16'h0, "R7 R10 ptr kept after hit");
        idle(3);

        // R5: context switch of core 1 to class 2
        cfg_write(2'd1, 1, 16'h0002);
        send(1, 7, 16'hFFFF, 16'h0, "R5 remapped core uses mask2");
        send(0, 7, 16'hFFFF, 16'h0, "R5 other core unchanged");
        idle(4);

        chk("R6 all responses seen", 32'(exp_q.size()), 0);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule